// File: doc/BRIEF.md
# Policy-Selectable Data Cache Controller

This block is a small direct-mapped data cache that sits between a load/store requester and a word-wide memory port. Each request carries a two-bit page policy code. The code selects one of three handlings for that access: a bypass of the array, write-through, or copy-back. The array holds 16 lines of four 32-bit words. Each line has a valid bit, a modified bit and a tag. A byte address splits into bits [1:0] (ignored, because accesses are whole aligned words), word offset [3:2], line index [7:4] and tag [31:8].

The requester side uses a valid/ready handshake. Load data returns on a registered response strobe. A load or store that hits completes without touching memory. The requester can present the next access in the cycle after acceptance, so independent accesses overlap an outstanding load. A two-entry store queue sits in front of memory. It takes write-through and uncached stores, so those stores do not wait for the memory port.

On a miss that allocates, a modified victim is first written back one word per transfer at offsets 0 to 3. The new line is then fetched the same way. Every memory read, whether a line fetch or an uncached load, waits until the store queue is empty. This keeps memory order intact. The memory port returns read data in the cycle of the handshake.

Top module: `dcache_ctl`

## Requirements
- R1: While reset is held, and afterwards until the first request, `rsp_valid` and `mem_valid` are low and `req_ready` is high. After reset every line is invalid, so the first cacheable load misses.
- R2: A load that hits, accepted in cycle c, drives `rsp_valid` with the line word in cycle c+2. Consecutive hits are accepted in consecutive cycles with no stall and no memory traffic.
- R3: A load miss on a line whose victim is clean or invalid reads four words from memory at the line base plus 0x0, 0x4, 0x8 and 0xC, in that order. It then returns the requested word. A memory request holds its address, direction and data until `mem_ready`.
- R4: A copy-back (code 2'b10) store that hits updates the line and marks it modified, with no memory write. A later load returns the stored word.
- R5: When allocation replaces a modified line, the four old words are written to the victim's address at offsets 0x0 to 0xC in order before the fill begins. A clean victim causes no write.
- R6: A copy-back store that misses fetches the line, merges the store into it and marks it modified. It produces no memory write.
- R7: A write-through (code 2'b01) store that hits updates the line and sends exactly one memory write of that word. Write-through loads allocate like copy-back loads.
- R8: A write-through store that misses sends one memory write and allocates nothing. A following load of that address misses and returns the stored word.
- R9: A non-cached (code 2'b00) load issues one memory read at its own address, only after all queued stores have reached memory, and allocates nothing. A non-cached store goes to memory through the store queue.
- R10: The store queue holds two words. Stores are accepted without stall while it has room. Once two are queued and a further store is waiting, `req_ready` stays low until an entry retires. Queued stores reach memory in issue order.
- R11: Policy code 2'b11 is handled as non-cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester presents an access |
| req_ready | output | 1 | Access accepted this cycle when high with req_valid |
| req_we | input | 1 | 1 = store, 0 = load |
| req_pol | input | 2 | Page policy: 00 non-cached, 01 write-through, 10 copy-back, 11 non-cached |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid, one cycle per load |
| rsp_rdata | output | 32 | Load data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address in bytes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready on a read |

## Verification
The assertions rely on two properties of the inputs. First, memory raises `mem_ready` only while `mem_valid` is high. Second, every address is word aligned. The bench's memory model derives ready from valid gated by an enable, and every address the bench drives has zero low bits. They also rely on the requester keeping its access stable until it is accepted, which the bench's driver does by leaving the request in place until it sees `req_ready`. The store-queue overflow checks depend on the memory side stalling. For that, the bench holds the memory enable low only around the back-pressure case.

// File: rtl/dc_pkg.sv
// Shared types for the data cache controller.
// Assumes: the policy code is supplied with every access by the requester.
package dc_pkg;

    typedef enum logic [1:0] {
        POL_NC  = 2'b00,
        POL_WT  = 2'b01,
        POL_CB  = 2'b10,
        POL_RSV = 2'b11
    } pol_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WB   = 2'b01,
        ST_FILL = 2'b10,
        ST_NCRD = 2'b11
    } ctl_st_e;

endpackage

// File: rtl/dc_wbuf.sv
// Store queue in front of memory: a small circular FIFO of address/data pairs.
// Assumes: push is never raised when full and pop never when empty.
module dc_wbuf #(
    parameter int W     = 64,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  ent_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Next-pointer helper with wrap at DEPTH.
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) ent_q[wr_ptr] <= push_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = ent_q[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/dc_array.sv
// Tag, state and data storage for a direct-mapped cache with combinational read.
// Assumes: one line (idx) is addressed per cycle; install clears the modified bit.
module dc_array #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int TAGW  = 24,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] idx,
    input  logic [$clog2(WORDS)-1:0] rd_off,
    output logic [TAGW-1:0]          rd_tag,
    output logic                     rd_valid,
    output logic                     rd_dirty,
    output logic [DW-1:0]            rd_word,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_off,
    input  logic [DW-1:0]            wr_data,
    input  logic                     set_dirty,
    input  logic                     inst_en,
    input  logic [TAGW-1:0]          inst_tag
);
    localparam int IDXW = $clog2(LINES);
    localparam int OFFW = $clog2(WORDS);

    logic [DW-1:0]   data_q [LINES*WORDS];
    logic [LINES-1:0] valid_q, dirty_q;
    logic [TAGW-1:0]  tag_q [LINES];

    // Word storage, one write port.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[{idx, wr_off}] <= wr_data;
    end

    // Per-line tag, valid and modified state.
    for (genvar l = 0; l < LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[l] <= 1'b0;
                dirty_q[l] <= 1'b0;
                tag_q[l]   <= '0;
            end else if (inst_en && idx == IDXW'(l)) begin
                valid_q[l] <= 1'b1;
                dirty_q[l] <= 1'b0;
                tag_q[l]   <= inst_tag;
            end else if (set_dirty && idx == IDXW'(l)) begin
                dirty_q[l] <= 1'b1;
            end
        end
    end

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_word  = data_q[{idx, rd_off}];

    // R4: the modified bit is only ever set on a resident line.
    p_dirty_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_dirty |-> rd_valid);

    logic unused_ok;
    assign unused_ok = &{1'b0, OFFW[0]};

endmodule

// File: rtl/dcache_ctl.sv
// Direct-mapped data cache controller with a per-access page policy.
// One request register (s1) holds the access under service; hits finish from it
// in one cycle into the response register. Misses run a write-back/fill sequence.
// Assumes: word-aligned addresses, memory raises ready only with valid, and
// read data is valid in the handshake cycle.
module dcache_ctl
    import dc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINES      = 16,
    parameter int WORDS      = 4,
    parameter int WBUF_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [1:0]    req_pol,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int BOFF = $clog2(DW / 8);
    localparam int OFFW = $clog2(WORDS);
    localparam int IDXW = $clog2(LINES);
    localparam int TAGW = AW - IDXW - OFFW - BOFF;
    localparam logic [OFFW-1:0] LAST = OFFW'(WORDS - 1);

    // Request register.
    logic          s1_valid, s1_we;
    pol_e          s1_pol;
    logic [AW-1:0] s1_addr;
    logic [DW-1:0] s1_wdata;

    ctl_st_e        st;
    logic [OFFW-1:0] cnt;

    logic [TAGW-1:0] s1_tag;
    logic [IDXW-1:0] s1_idx;
    logic [OFFW-1:0] s1_off;
    assign s1_tag = s1_addr[AW-1 -: TAGW];
    assign s1_idx = s1_addr[BOFF+OFFW +: IDXW];
    assign s1_off = s1_addr[BOFF +: OFFW];

    // Array interface.
    logic [TAGW-1:0] a_tag;
    logic            a_valid, a_dirty;
    logic [DW-1:0]   a_word;
    logic            a_wr, a_set_dirty, a_inst, st_wr;
    logic [OFFW-1:0] a_rd_off, a_wr_off;
    logic [DW-1:0]   a_wr_data;

    // Store queue interface.
    logic               wb_push, wb_pop, wb_empty, wb_full;
    logic [AW+DW-1:0]   wb_head;

    logic is_nc, is_wt, hit, mem_hs, done, start_miss, start_nc;

    assign is_nc  = (s1_pol == POL_NC) || (s1_pol == POL_RSV);
    assign is_wt  = (s1_pol == POL_WT);
    assign hit    = a_valid && (a_tag == s1_tag);
    assign mem_hs = mem_valid && mem_ready;

    // Completion of the access held in s1 and the side effects of finishing it.
    always_comb begin
        done        = 1'b0;
        wb_push     = 1'b0;
        st_wr       = 1'b0;
        a_set_dirty = 1'b0;
        if (s1_valid && st == ST_IDLE) begin
            if (s1_we) begin
                if (is_nc) begin
                    wb_push = !wb_full;
                    done    = !wb_full;
                end else if (is_wt) begin
                    wb_push = !wb_full;
                    done    = !wb_full;
                    st_wr   = !wb_full && hit;
                end else if (hit) begin
                    done        = 1'b1;
                    st_wr       = 1'b1;
                    a_set_dirty = 1'b1;
                end
            end else if (!is_nc && hit) begin
                done = 1'b1;
            end
        end
        if (st == ST_NCRD && mem_hs) done = 1'b1;
    end

    // Start conditions for memory sequences; reads wait for an empty queue.
    assign start_miss = s1_valid && st == ST_IDLE && !is_nc && !hit &&
                        !(is_wt && s1_we) && wb_empty;
    assign start_nc   = s1_valid && st == ST_IDLE && is_nc && !s1_we && wb_empty;

    assign req_ready = !s1_valid || done;

    // Capture a new access or retire the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_we    <= 1'b0;
            s1_pol   <= POL_NC;
            s1_addr  <= '0;
            s1_wdata <= '0;
        end else if (req_valid && req_ready) begin
            s1_valid <= 1'b1;
            s1_we    <= req_we;
            s1_pol   <= pol_e'(req_pol);
            s1_addr  <= req_addr;
            s1_wdata <= req_wdata;
        end else if (done) begin
            s1_valid <= 1'b0;
        end
    end

    // Miss / uncached-read sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_nc)        st <= ST_NCRD;
                    else if (start_miss) st <= (a_valid && a_dirty) ? ST_WB : ST_FILL;
                end
                ST_WB: if (mem_hs) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) st <= ST_FILL;
                end
                ST_FILL: if (mem_hs) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) st <= ST_IDLE;
                end
                ST_NCRD: if (mem_hs) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Load response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done && !s1_we;
            if (done && !s1_we) rsp_rdata <= (st == ST_NCRD) ? mem_rdata : a_word;
        end
    end

    // Memory port steering: sequencer when busy, store queue head when idle.
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {a_tag, s1_idx, cnt, {BOFF{1'b0}}};
                mem_wdata = a_word;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {s1_tag, s1_idx, cnt, {BOFF{1'b0}}};
            end
            ST_NCRD: begin
                mem_valid = 1'b1;
                mem_addr  = s1_addr;
            end
            default: begin
                mem_valid = !wb_empty;
                mem_we    = 1'b1;
                mem_addr  = wb_head[AW+DW-1 -: AW];
                mem_wdata = wb_head[DW-1:0];
            end
        endcase
    end

    assign wb_pop    = (st == ST_IDLE) && !wb_empty && mem_ready;
    assign a_rd_off  = (st == ST_WB) ? cnt : s1_off;
    assign a_wr      = st_wr || (st == ST_FILL && mem_hs);
    assign a_wr_off  = (st == ST_FILL) ? cnt : s1_off;
    assign a_wr_data = (st == ST_FILL) ? mem_rdata : s1_wdata;
    assign a_inst    = (st == ST_FILL) && mem_hs && (cnt == LAST);

    dc_array #(
        .LINES(LINES), .WORDS(WORDS), .TAGW(TAGW), .DW(DW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (s1_idx),
        .rd_off   (a_rd_off),
        .rd_tag   (a_tag),
        .rd_valid (a_valid),
        .rd_dirty (a_dirty),
        .rd_word  (a_word),
        .wr_en    (a_wr),
        .wr_off   (a_wr_off),
        .wr_data  (a_wr_data),
        .set_dirty(a_set_dirty),
        .inst_en  (a_inst),
        .inst_tag (s1_tag)
    );

    dc_wbuf #(
        .W(AW + DW), .DEPTH(WBUF_DEPTH)
    ) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wb_push),
        .push_data({s1_addr, s1_wdata}),
        .pop      (wb_pop),
        .head     (wb_head),
        .empty    (wb_empty),
        .full     (wb_full)
    );

    // R1: an empty request stage never blocks the requester.
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |-> req_ready);
    // R2: a response always follows an access held in the request stage.
    p_rsp_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(s1_valid));
    // R3: a pending memory request holds until accepted.
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_we) && $stable(mem_wdata)));
    // R5: write-back traffic only comes from a valid modified line.
    p_wb_only_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && st == ST_WB) |-> (a_valid && a_dirty));
    // R9: memory reads only start once the store queue has drained.
    p_read_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> wb_empty);

endmodule

// File: tb/sim_dcache_ctl.sv
module sim_dcache_ctl;
    import dc_pkg::*;

    localparam int CLK_PERIOD = 10;
    typedef logic [64:0] ent_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_we;
    logic [1:0]  req_pol;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_en;

    int checks = 0;
    int errors = 0;
    int stalls = 0;

    logic [31:0] mem_model [int unsigned];
    logic [31:0] exp_rd [$];
    string       exp_tag [$];
    ent_t        log_q [$];
    ent_t        exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dcache_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_pol(req_pol), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic logic [31:0] mrd(logic [31:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return init_val(a);
    endfunction

    assign mem_ready = mem_valid && mem_en;

    // Memory model: read data refreshed mid-cycle, writes and log at the edge.
    always @(negedge clk) mem_rdata = mrd(mem_addr);
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            log_q.push_back({mem_we, mem_addr, mem_we ? mem_wdata : 32'h0});
            if (mem_we) mem_model[mem_addr] = mem_wdata;
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected load data as responses appear.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_rd.size() == 0) begin
                check(1'b0, "R2", "unexpected response", rsp_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_rd.pop_front();
                automatic string t = exp_tag.pop_front();
                check(rsp_rdata === e, t, "load data", rsp_rdata, e);
            end
        end
    end

    // Driver: hold the access until accepted, return at the following negedge.
    task automatic issue(bit we, logic [1:0] pol, logic [31:0] addr,
                         logic [31:0] wd, logic [31:0] exp, string req);
        req_valid = 1'b1; req_we = we; req_pol = pol;
        req_addr = addr; req_wdata = wd;
        if (!we) begin
            exp_rd.push_back(exp);
            exp_tag.push_back(req);
        end
        #1;
        while (!req_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(negedge clk);
    endtask

    task automatic settle();
        req_valid = 1'b0;
        repeat (25) @(negedge clk);
    endtask

    task automatic expect_mem(bit we, logic [31:0] a, logic [31:0] d);
        exp_q.push_back({we, a, we ? d : 32'h0});
    endtask

    task automatic expect_fill(logic [31:0] base);
        for (int i = 0; i < 4; i++) expect_mem(1'b0, base + 32'(4*i), 32'h0);
    endtask

    task automatic chk_log(string req);
        bit ok = (log_q.size() == exp_q.size());
        ent_t a = '0, e = '0;
        if (ok) begin
            for (int i = 0; i < log_q.size(); i++) begin
                if (ok && log_q[i] !== exp_q[i]) begin
                    ok = 1'b0; a = log_q[i]; e = exp_q[i];
                end
            end
        end else begin
            a = 65'(log_q.size()); e = 65'(exp_q.size());
        end
        check(ok, req, "memory traffic (addr/count)", a[63:32], e[63:32]);
        log_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_pol = 2'b00;
        req_addr = '0; req_wdata = '0; mem_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        check(mem_valid == 1'b0, "R1", "mem_valid in reset", 32'(mem_valid), 0);
        check(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R3: first copy-back load misses and fills in offset order
        issue(1'b0, 2'b10, 32'h100, 0, init_val(32'h100), "R3");
        settle();
        expect_fill(32'h100);
        chk_log("R3");

        // R2: hit latency and back-to-back hits
        issue(1'b0, 2'b10, 32'h104, 0, init_val(32'h104), "R2");
        req_valid = 1'b0;
        check(rsp_valid == 1'b0, "R2", "rsp one cycle after accept", 32'(rsp_valid), 0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2", "rsp two cycles after accept", 32'(rsp_valid), 1);
        s0 = stalls;
        for (int i = 0; i < 4; i++)
            issue(1'b0, 2'b10, 32'h100 + 32'(4*i), 0, init_val(32'h100 + 32'(4*i)), "R2");
        settle();
        check(stalls == s0, "R2", "stalls during hit stream", 32'(stalls - s0), 0);
        chk_log("R2");

        // R4: copy-back store hit stays local
        issue(1'b1, 2'b10, 32'h108, 32'hDEAD0001, 0, "R4");
        issue(1'b0, 2'b10, 32'h108, 0, 32'hDEAD0001, "R4");
        settle();
        chk_log("R4");

        // R5: modified victim written back before fill
        issue(1'b0, 2'b10, 32'h1100, 0, init_val(32'h1100), "R5");
        settle();
        expect_mem(1'b1, 32'h100, init_val(32'h100));
        expect_mem(1'b1, 32'h104, init_val(32'h104));
        expect_mem(1'b1, 32'h108, 32'hDEAD0001);
        expect_mem(1'b1, 32'h10C, init_val(32'h10C));
        expect_fill(32'h1100);
        chk_log("R5");
        // R5: clean victim, no write-back
        issue(1'b0, 2'b10, 32'h2100, 0, init_val(32'h2100), "R5");
        settle();
        expect_fill(32'h2100);
        chk_log("R5");

        // R6: copy-back store miss fetches, merges, no write
        issue(1'b1, 2'b10, 32'h230, 32'hCAFE0005, 0, "R6");
        issue(1'b0, 2'b10, 32'h230, 0, 32'hCAFE0005, "R6");
        settle();
        expect_fill(32'h230);
        chk_log("R6");

        // R7: write-through load allocates, store hit writes through
        issue(1'b0, 2'b01, 32'h340, 0, init_val(32'h340), "R7");
        settle();
        expect_fill(32'h340);
        chk_log("R7");
        issue(1'b1, 2'b01, 32'h344, 32'hBEEF0006, 0, "R7");
        issue(1'b0, 2'b01, 32'h344, 0, 32'hBEEF0006, "R7");
        settle();
        expect_mem(1'b1, 32'h344, 32'hBEEF0006);
        chk_log("R7");

        // R8: write-through store miss does not allocate
        issue(1'b1, 2'b01, 32'h450, 32'h77770007, 0, "R8");
        settle();
        expect_mem(1'b1, 32'h450, 32'h77770007);
        chk_log("R8");
        issue(1'b0, 2'b01, 32'h450, 0, 32'h77770007, "R8");
        settle();
        expect_fill(32'h450);
        chk_log("R8");

        // R9: uncached load after uncached store sees the store, no allocation
        issue(1'b1, 2'b00, 32'h560, 32'h88880008, 0, "R9");
        issue(1'b0, 2'b00, 32'h560, 0, 32'h88880008, "R9");
        settle();
        expect_mem(1'b1, 32'h560, 32'h88880008);
        expect_mem(1'b0, 32'h560, 0);
        chk_log("R9");
        issue(1'b0, 2'b10, 32'h564, 0, init_val(32'h564), "R9");
        settle();
        expect_fill(32'h560);
        chk_log("R9");

        // R10: two-entry queue absorbs stores, then back-pressure
        mem_en = 1'b0;
        s0 = stalls;
        for (int i = 0; i < 3; i++)
            issue(1'b1, 2'b00, 32'h600 + 32'(4*i), 32'hA0 + 32'(i), 0, "R10");
        check(stalls == s0, "R10", "stalls for first stores", 32'(stalls - s0), 0);
        req_valid = 1'b1; req_we = 1'b1; req_pol = 2'b00;
        req_addr = 32'h60C; req_wdata = 32'hA3;
        #1;
        check(req_ready == 1'b0, "R10", "ready with full queue", 32'(req_ready), 0);
        repeat (3) @(negedge clk);
        #1;
        check(req_ready == 1'b0, "R10", "ready still held", 32'(req_ready), 0);
        mem_en = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        settle();
        for (int i = 0; i < 4; i++)
            expect_mem(1'b1, 32'h600 + 32'(4*i), 32'hA0 + 32'(i));
        chk_log("R10");

        // R11: reserved code behaves as uncached
        issue(1'b0, 2'b11, 32'h680, 0, init_val(32'h680), "R11");
        settle();
        expect_mem(1'b0, 32'h680, 0);
        chk_log("R11");
        issue(1'b0, 2'b10, 32'h680, 0, init_val(32'h680), "R11");
        settle();
        expect_fill(32'h680);
        chk_log("R11");

        check(exp_rd.size() == 0, "R2", "responses outstanding", 32'(exp_rd.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule